// File: doc/BRIEF.md
# Condition Code Evaluator

This block decides whether a conditional instruction or branch should execute. It takes the four stored arithmetic flags and a 4-bit condition selector. The flags are negative (N), zero (Z), carry (C) and overflow (V). It produces a single pass bit. The block holds no flags of its own; it only evaluates them. It neither computes a branch target nor fetches anything.

Conditions are arranged as complementary pairs. An even selector names a test, and the next odd selector names its inverse. The block therefore evaluates eight base predicates and picks one of them with the upper three selector bits. The lowest selector bit inverts the chosen predicate.

The last pair holds the unconditional code (always passes) and a code that never passes. The pass bit is registered by default, with a synchronous active-high reset. A parameter can instead make the output purely combinational.

Top module: `cond_eval`

## Requirements
- R1: Selector 0 passes exactly when Z is 1; selector 1 passes exactly when Z is 0.
- R2: Selector 2 passes exactly when C is 1; selector 3 passes exactly when C is 0.
- R3: Selector 4 passes exactly when N is 1; selector 5 passes exactly when N is 0.
- R4: Selector 6 passes exactly when V is 1; selector 7 passes exactly when V is 0.
- R5: Selector 8 (unsigned higher) passes when C is 1 and Z is 0; selector 9 (unsigned lower or same) passes when C is 0 or Z is 1.
- R6: Selector 10 (signed greater or equal) passes when N equals V; selector 11 (signed less) passes when N differs from V.
- R7: Selector 12 (signed greater) passes when Z is 0 and N equals V; selector 13 (signed less or equal) passes when Z is 1 or N differs from V.
- R8: Selector 14 passes for every flag combination; selector 15 never passes.
- R9: For every flag combination and every k from 0 to 7, selectors 2k and 2k+1 give opposite results.
- R10: With the default registered output, `pass_o` shows the result for the flags and selector sampled at the previous rising clock edge. A rising edge with `rst` high forces `pass_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_v | input | 1 | Overflow flag |
| cond_sel | input | 4 | Condition selector, encoding per R1 to R8 |
| pass_o | output | 1 | Condition passed |

## Verification
Apart from the output register, the block has no state. A wrong predicate or a wrong select path therefore shows up at `pass_o` exactly one clock after the offending flag and selector combination is applied. Sweeping all 256 combinations of flags and selector exposes any such fault at once.

A wrong output register shows up as a result that is stale or that changes between edges, and also within one cycle. A wrong reset shows up as a nonzero `pass_o` after a reset edge.

// File: rtl/cond_pkg.sv
package cond_pkg;
  localparam int SEL_W = 4;
  localparam int PAIR_W = SEL_W - 1;
  localparam int PAIRS = 1 << PAIR_W;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  // Base predicate index = selector[3:1]; selector[0] inverts.
  typedef enum logic [PAIR_W-1:0] {
    P_ZERO   = 3'd0,
    P_CARRY  = 3'd1,
    P_NEG    = 3'd2,
    P_OVF    = 3'd3,
    P_UHI    = 3'd4,
    P_SGE    = 3'd5,
    P_SGT    = 3'd6,
    P_TRUE   = 3'd7
  } pair_e;
endpackage

// File: rtl/cond_base_eval.sv
module cond_base_eval
  import cond_pkg::*;
(
  input  flags_t           flags,
  output logic [PAIRS-1:0] base
);
  logic n_eq_v;

  always_comb begin
    n_eq_v          = (flags.n == flags.v);
    base            = '0;
    base[P_ZERO]    = flags.z;
    base[P_CARRY]   = flags.c;
    base[P_NEG]     = flags.n;
    base[P_OVF]     = flags.v;
    base[P_UHI]     = flags.c & ~flags.z;
    base[P_SGE]     = n_eq_v;
    base[P_SGT]     = ~flags.z & n_eq_v;
    base[P_TRUE]    = 1'b1;
  end
endmodule

// File: rtl/cond_pick.sv
module cond_pick
  import cond_pkg::*;
(
  input  logic [PAIRS-1:0] base,
  input  logic [SEL_W-1:0] sel,
  output logic             pass
);
  logic chosen;

  always_comb begin
    chosen = base[sel[SEL_W-1:1]];
    pass   = chosen ^ sel[0];
  end
endmodule

// File: rtl/cond_eval.sv
module cond_eval
  import cond_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flag_n,
  input  logic             flag_z,
  input  logic             flag_c,
  input  logic             flag_v,
  input  logic [SEL_W-1:0] cond_sel,
  output logic             pass_o
);
  flags_t           flags;
  logic [PAIRS-1:0] base;
  logic             pass_comb;

  assign flags = '{n: flag_n, z: flag_z, c: flag_c, v: flag_v};

  cond_base_eval u_base (
    .flags (flags),
    .base  (base)
  );

  cond_pick u_pick (
    .base (base),
    .sel  (cond_sel),
    .pass (pass_comb)
  );

  generate
    if (REG_OUT) begin : g_reg
      logic pass_q;

      always_ff @(posedge clk) begin
        if (rst) pass_q <= 1'b0;
        else     pass_q <= pass_comb;
      end
      assign pass_o = pass_q;

      a_r10_reset_clears: assert property (@(posedge clk) rst |=> !pass_o);
      a_r8_always: assert property (@(posedge clk) disable iff (rst)
        (cond_sel == 4'd14) |=> pass_o);
      a_r8_never: assert property (@(posedge clk) disable iff (rst)
        (cond_sel == 4'd15) |=> !pass_o);
      a_r1_eq: assert property (@(posedge clk) disable iff (rst)
        (cond_sel == 4'd0) |=> (pass_o == $past(flag_z)));
      a_r5_hi: assert property (@(posedge clk) disable iff (rst)
        (cond_sel == 4'd8 && flag_c && !flag_z) |=> pass_o);
      a_r6_ge: assert property (@(posedge clk) disable iff (rst)
        (cond_sel == 4'd10 && flag_n == flag_v) |=> pass_o);
      a_r7_gt: assert property (@(posedge clk) disable iff (rst)
        (cond_sel == 4'd12 && flag_z) |=> !pass_o);
    end else begin : g_comb
      assign pass_o = pass_comb;

      always_comb begin
        if (cond_sel == 4'd15) a_r8_never_c: assert (!pass_o);
      end
    end
  endgenerate
endmodule

// File: tb/cond_eval_tb.sv
module cond_eval_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       fn, fz, fc, fv;
  logic [3:0] sel;
  logic       pass_o;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;
  logic       res [16][16];

  always #5 clk = ~clk;

  cond_eval dut_i (
    .clk(clk), .rst(rst), .flag_n(fn), .flag_z(fz), .flag_c(fc),
    .flag_v(fv), .cond_sel(sel), .pass_o(pass_o)
  );

  function automatic logic expect_pass(input logic [3:0] f, input logic [3:0] s);
    logic n, z, c, v;
    {n, z, c, v} = f;
    case (s)
      4'd0:  return z;                  // R1
      4'd1:  return !z;                 // R1
      4'd2:  return c;                  // R2
      4'd3:  return !c;                 // R2
      4'd4:  return n;                  // R3
      4'd5:  return !n;                 // R3
      4'd6:  return v;                  // R4
      4'd7:  return !v;                 // R4
      4'd8:  return c && !z;            // R5
      4'd9:  return !c || z;            // R5
      4'd10: return n == v;             // R6
      4'd11: return n != v;             // R6
      4'd12: return !z && (n == v);     // R7
      4'd13: return z || (n != v);      // R7
      4'd14: return 1'b1;               // R8
      default: return 1'b0;             // R8
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] s);
    case (s[3:1])
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      3'd6: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: pass_o=%b expected=%b (sel=%0d nzcv=%b%b%b%b)",
               req, act, exp, sel, fn, fz, fc, fv);
    end
  endtask

  initial begin
    rst = 1'b1; sel = 4'd14; {fn, fz, fc, fv} = 4'b0000;
    @(posedge clk); @(posedge clk); #2;
    check("R10 reset", pass_o, 1'b0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #2;
    check("R10 first", pass_o, 1'b1);
    // Exhaustive sweep
    for (int f = 0; f < 16; f++) begin
      for (int s = 0; s < 16; s++) begin
        @(negedge clk);
        {fn, fz, fc, fv} = f[3:0];
        sel = s[3:0];
        @(posedge clk); #2;
        res[f][s] = pass_o;
        check(req_of(s[3:0]), pass_o, expect_pass(f[3:0], s[3:0]));
      end
    end
    // R9: complementary pairs
    for (int f = 0; f < 16; f++) begin
      for (int k = 0; k < 8; k++) begin
        n_chk++;
        if (res[f][2*k] === res[f][2*k+1]) begin
          n_bad++;
          $display("FAIL R9: flags=%0d pair=%0d both=%b expected opposite",
                   f, k, res[f][2*k]);
        end
      end
    end
    // R10: output holds between edges, updates at the edge
    @(negedge clk); sel = 4'd15;
    @(posedge clk); #2;
    check("R10 set0", pass_o, 1'b0);
    @(negedge clk); sel = 4'd14;
    #2; check("R10 hold", pass_o, 1'b0);
    @(posedge clk); #2;
    check("R10 update", pass_o, 1'b1);
    // R10: reset mid-run while condition passes
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #2;
    check("R10 mid reset", pass_o, 1'b0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #2;
    check("R10 recover", pass_o, 1'b1);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule